// File: doc/BRIEF.md
# Bit-Addressed Field Memory Controller

This block sits between a processor core and a 16-bit-wide synchronous word memory. The core addresses memory in bits, not bytes. Each request names a start bit and a field width from 1 to 32 bits. The field may begin at any bit, so it can spread over one, two or three memory words. The controller breaks every request into the 16-bit memory cycles it needs. Barrel shifters move the field to and from its position inside those words.

A read returns the field right-justified. A write can store a core operand into the field. It can also merge the operand with the field's current contents using a logical or arithmetic operation. Any word that the field covers only in part is read first and written back with its other bits unchanged. A plain store that covers a whole word does not read that word. The core uses a valid/ready handshake. The controller then works on that one request and raises a one-cycle done pulse after its last memory cycle.

Top module: `bitfield_mem_ctrl`

## Requirements
- R1: While reset is held and immediately after it, `req_ready` is 1 and `mem_re`, `mem_we` and `rsp_done` are 0.
- R2: Bit address A lies in word A>>4 at bit A[3:0] (word w, bit b holds bit address 16w+b). A request at A with width W uses words A>>4 up to A>>4 + ((A[3:0]+W-1)>>4). Word addresses increase by one and wrap modulo 2^16, and the words are written in ascending order.
- R3: A read (`req_write`=0) returns the field's bit 0 (the bit at address A) in `rsp_rdata[0]`, and all bits above the field are zero.
- R4: When `req_sext`=1 on a read, field bit W-1 is copied into every bit of `rsp_rdata` above the field.
- R5: A write changes only the W bits of the field. Every other memory bit keeps its value.
- R6: `req_op` selects the new field value from the old field F and operand D: 0 = D, 1 = F&D, 2 = F|D, 3 = F^D, 4 = F+D, 5 = F-D. The result is truncated to W bits. Codes 6 and 7 act as code 0. On reads the opcode is ignored.
- R7: A write with code 0 (or 6 or 7) issues no read of a word that the field covers completely. Every other word of a write, and every word of a read, is read exactly once.
- R8: `req_wlen` holds width minus one, so the values 0..31 select widths 1..32.
- R9: `req_ready` is 1 only while the controller is idle, and a request is taken when `req_valid` and `req_ready` are both 1. `rsp_done` is a one-cycle pulse after the request's last memory cycle. During that pulse `rsp_rdata` holds the read field, or for a write the truncated field value that was written.
- R10: `mem_re` and `mem_we` are never 1 together. Read data is taken from `mem_rdata` one cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_addr | input | 20 | Start bit address of the field |
| req_wlen | input | 5 | Field width minus one |
| req_write | input | 1 | 1 = write or modify, 0 = read |
| req_op | input | 3 | Field operation code |
| req_sext | input | 1 | Sign-extend read result |
| req_wdata | input | 32 | Operand D, right-justified |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read field or written value |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
The hardest case to reach is a plain store whose field covers some words in full and others only in part. An example is a 32-bit field starting at bit offset 8: its middle word must not be read, while its two edge words must be read and merged. The stimulus reaches this case with directed writes at offsets 0 and 8 and widths of 16 and 32. It also uses address-wrapping requests near the top of the space. Randomized requests then mix all opcodes, widths and offsets. On every clock the bench checks each memory strobe against the word set and the skip set predicted by a behavioural bit-level model.

// File: rtl/bfm_pkg.sv
// Package: shared types for the bit-addressed field memory controller.
// Assumes a 3-bit operation code on the core request.
package bfm_pkg;

    typedef enum logic [2:0] {
        OP_REPL = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5
    } bf_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_CAP,
        S_WR,
        S_DONE
    } bf_state_e;

    // Map a raw request code onto an operation; unused codes store plainly.
    function automatic bf_op_e to_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_AND;
            3'd2:    return OP_OR;
            3'd3:    return OP_XOR;
            3'd4:    return OP_ADD;
            3'd5:    return OP_SUB;
            default: return OP_REPL;
        endcase
    endfunction

endpackage

// File: rtl/bfm_span.sv
// Module: bfm_span
// Works out which memory words a field touches, the field mask, the mask
// of the field inside the multi-word window, and which words must be read.
// Assumes the offset is below WORD_W and the width is wm1_i+1.
module bfm_span #(
    parameter int FIELD_W   = 32,
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 3,
    parameter int OFF_W     = 4,
    parameter int LEN_W     = 5,
    parameter int IDX_W     = 2
) (
    input  logic [OFF_W-1:0]            off_i,
    input  logic [LEN_W-1:0]            wm1_i,
    input  logic                        rd_all_i,
    output logic [FIELD_W-1:0]          fmask_o,
    output logic [MAX_WORDS*WORD_W-1:0] wmask_o,
    output logic [IDX_W-1:0]            last_o,
    output logic [MAX_WORDS-1:0]        need_rd_o
);
    localparam int WIN_W  = MAX_WORDS * WORD_W;
    localparam int SPAN_W = $clog2(WIN_W);

    logic [LEN_W:0]    width;
    logic [LEN_W:0]    rshift;
    logic [SPAN_W-1:0] end_bit;

    // Field mask, window mask and index of the last touched word.
    always_comb begin
        width   = (LEN_W+1)'(wm1_i) + (LEN_W+1)'(1);
        rshift  = (LEN_W+1)'(FIELD_W) - width;
        fmask_o = {FIELD_W{1'b1}} >> rshift;
        wmask_o = WIN_W'(fmask_o) << off_i;
        end_bit = SPAN_W'(off_i) + SPAN_W'(wm1_i);
        last_o  = IDX_W'(end_bit >> OFF_W);
    end

    // One read-need flag per window word.
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        assign need_rd_o[g] = (IDX_W'(g) <= last_o) &&
                              (rd_all_i || !(&wmask_o[g*WORD_W +: WORD_W]));
    end

endmodule

// File: rtl/bfm_alu.sv
// Module: bfm_alu
// Combines the old field value with the core operand and truncates the
// result to the field width. Assumes both inputs are right-justified.
module bfm_alu
    import bfm_pkg::*;
#(
    parameter int FIELD_W = 32
) (
    input  bf_op_e               op_i,
    input  logic [FIELD_W-1:0]   old_i,
    input  logic [FIELD_W-1:0]   opnd_i,
    input  logic [FIELD_W-1:0]   fmask_i,
    output logic [FIELD_W-1:0]   res_o
);
    logic [FIELD_W-1:0] raw;

    // Select the operation, then clip to the field width.
    always_comb begin
        case (op_i)
            OP_AND:  raw = old_i & opnd_i;
            OP_OR:   raw = old_i | opnd_i;
            OP_XOR:  raw = old_i ^ opnd_i;
            OP_ADD:  raw = old_i + opnd_i;
            OP_SUB:  raw = old_i - opnd_i;
            default: raw = opnd_i;
        endcase
        res_o = raw & fmask_i;
    end

endmodule

// File: rtl/bfm_window.sv
// Module: bfm_window
// Barrel-shifts a field out of the captured word window (with optional sign
// extension) and shifts a new field value back into the window.
// Assumes wmask_i equals fmask_i shifted left by off_i.
module bfm_window #(
    parameter int FIELD_W   = 32,
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 3,
    parameter int OFF_W     = 4,
    parameter int LEN_W     = 5
) (
    input  logic [MAX_WORDS*WORD_W-1:0] win_i,
    input  logic [OFF_W-1:0]            off_i,
    input  logic [MAX_WORDS*WORD_W-1:0] wmask_i,
    input  logic [FIELD_W-1:0]          fmask_i,
    input  logic [LEN_W-1:0]            wm1_i,
    input  logic                        sext_i,
    input  logic [FIELD_W-1:0]          res_i,
    output logic [FIELD_W-1:0]          field_o,
    output logic [FIELD_W-1:0]          rdata_o,
    output logic [MAX_WORDS*WORD_W-1:0] win_o
);
    localparam int WIN_W = MAX_WORDS * WORD_W;

    logic [WIN_W-1:0] shifted;
    logic             top_bit;

    // Extract path: align right, mask, optionally sign-extend.
    always_comb begin
        shifted = win_i >> off_i;
        field_o = shifted[FIELD_W-1:0] & fmask_i;
        top_bit = field_o[wm1_i];
        rdata_o = field_o | ((sext_i && top_bit) ? ~fmask_i : '0);
    end

    // Insert path: clear the field bits and OR in the shifted new value.
    always_comb begin
        win_o = (win_i & ~wmask_i) | (WIN_W'(res_i & fmask_i) << off_i);
    end

endmodule

// File: rtl/bitfield_mem_ctrl.sv
// Module: bitfield_mem_ctrl (top)
// Turns bit-addressed field requests from a core into 16-bit word memory
// cycles: a read phase that fills a word window, then (for writes) a
// write phase from the merged window. Assumes a memory with one cycle of
// read latency and one request in flight at a time.
module bitfield_mem_ctrl
    import bfm_pkg::*;
#(
    parameter int FIELD_W = 32,
    parameter int WORD_W  = 16,
    parameter int MEM_AW  = 16,
    parameter int ADDR_W  = MEM_AW + $clog2(WORD_W),
    parameter int LEN_W   = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_wlen,
    input  logic               req_write,
    input  logic [2:0]         req_op,
    input  logic               req_sext,
    input  logic [FIELD_W-1:0] req_wdata,
    output logic               rsp_done,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic               mem_re,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata
);
    localparam int OFF_W     = $clog2(WORD_W);
    localparam int MAX_WORDS = (WORD_W + FIELD_W - 2) / WORD_W + 1;
    localparam int WIN_W     = MAX_WORDS * WORD_W;
    localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    bf_state_e          state;
    logic [MEM_AW-1:0]  base_q;
    logic [OFF_W-1:0]   off_q;
    logic [LEN_W-1:0]   wm1_q;
    logic               wr_q;
    bf_op_e             op_q;
    logic               sext_q;
    logic [FIELD_W-1:0] opnd_q;
    logic [IDX_W-1:0]   idx_q;
    logic [WIN_W-1:0]   win_q;

    logic [FIELD_W-1:0]   fmask;
    logic [WIN_W-1:0]     wmask;
    logic [IDX_W-1:0]     last_idx;
    logic [MAX_WORDS-1:0] need_rd;
    logic                 rd_all;
    logic [FIELD_W-1:0]   old_field;
    logic [FIELD_W-1:0]   rd_value;
    logic [FIELD_W-1:0]   result;
    logic [WIN_W-1:0]     new_win;
    logic                 at_last;

    assign rd_all  = !wr_q || (op_q != OP_REPL);
    assign at_last = (idx_q == last_idx);

    bfm_span #(
        .FIELD_W(FIELD_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS),
        .OFF_W(OFF_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_span (
        .off_i(off_q), .wm1_i(wm1_q), .rd_all_i(rd_all),
        .fmask_o(fmask), .wmask_o(wmask), .last_o(last_idx),
        .need_rd_o(need_rd)
    );

    bfm_window #(
        .FIELD_W(FIELD_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS),
        .OFF_W(OFF_W), .LEN_W(LEN_W)
    ) u_window (
        .win_i(win_q), .off_i(off_q), .wmask_i(wmask), .fmask_i(fmask),
        .wm1_i(wm1_q), .sext_i(sext_q), .res_i(result),
        .field_o(old_field), .rdata_o(rd_value), .win_o(new_win)
    );

    bfm_alu #(.FIELD_W(FIELD_W)) u_alu (
        .op_i(op_q), .old_i(old_field), .opnd_i(opnd_q),
        .fmask_i(fmask), .res_o(result)
    );

    // Port outputs decoded from the sequencer state.
    always_comb begin
        req_ready = (state == S_IDLE);
        rsp_done  = (state == S_DONE);
        rsp_rdata = wr_q ? result : rd_value;
        mem_re    = (state == S_RD_ISSUE) && need_rd[idx_q];
        mem_we    = (state == S_WR);
        mem_addr  = base_q + MEM_AW'(idx_q);
        mem_wdata = new_win[idx_q*WORD_W +: WORD_W];
    end

    // Sequencer: latch request, read needed words, write merged words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            base_q <= '0;
            off_q  <= '0;
            wm1_q  <= '0;
            wr_q   <= 1'b0;
            op_q   <= OP_REPL;
            sext_q <= 1'b0;
            opnd_q <= '0;
            idx_q  <= '0;
            win_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        base_q <= req_addr[ADDR_W-1:OFF_W];
                        off_q  <= req_addr[OFF_W-1:0];
                        wm1_q  <= req_wlen;
                        wr_q   <= req_write;
                        op_q   <= to_op(req_op);
                        sext_q <= req_sext;
                        opnd_q <= req_wdata;
                        idx_q  <= '0;
                        state  <= S_RD_ISSUE;
                    end
                end
                S_RD_ISSUE: begin
                    if (need_rd[idx_q]) begin
                        state <= S_RD_CAP;
                    end else if (at_last) begin
                        idx_q <= '0;
                        state <= wr_q ? S_WR : S_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_RD_CAP: begin
                    win_q[idx_q*WORD_W +: WORD_W] <= mem_rdata;
                    if (at_last) begin
                        idx_q <= '0;
                        state <= wr_q ? S_WR : S_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        state <= S_RD_ISSUE;
                    end
                end
                S_WR: begin
                    if (at_last) state <= S_DONE;
                    else         idx_q <= idx_q + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Marks that at least one clock has passed since reset released.
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_re && !mem_we && !rsp_done));

    // R2
    wr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && mem_we && $past(mem_we)) |->
            (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

    // R10
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (state == S_RD_CAP));

endmodule

// File: tb/bitfield_mem_ctrl_bench.sv
// Bench for bitfield_mem_ctrl: a word memory model, a bit-level reference
// model of memory and responses, per-clock strobe checks and end checks.
module bitfield_mem_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [4:0]  req_wlen = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_sext = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        mem_re;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem     [0:1023];
    logic [15:0] ref_mem [0:1023];

    always #5 clk = ~clk;

    bitfield_mem_ctrl u_bitfield_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wlen(req_wlen), .req_write(req_write),
        .req_op(req_op), .req_sext(req_sext), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Word memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [19:0] a, input logic [4:0] wm1,
                          input logic wr, input logic [2:0] op,
                          input logic sx, input logic [31:0] d);
        int width, off, n, nop, rd_exp, rd_cnt, wr_cnt, cyc;
        logic [15:0] base;
        logic [31:0] oldf, mask, res, exp;
        bit skip [0:2];
        bit mem_ok;
        logic [15:0] bad_w;
        width = int'(wm1) + 1;
        off   = int'(a[3:0]);
        base  = a[19:4];
        n     = (off + width - 1) / 16 + 1;
        mask  = (width == 32) ? 32'hFFFF_FFFF : ((32'h1 << width) - 32'h1);
        oldf  = '0;
        for (int k = 0; k < width; k++) begin
            logic [19:0] ba;
            ba = a + 20'(k);
            oldf[k] = ref_mem[ba[13:4]][ba[3:0]];
        end
        nop = (op > 3'd5) ? 0 : int'(op);
        case (nop)
            1: res = oldf & d;
            2: res = oldf | d;
            3: res = oldf ^ d;
            4: res = oldf + d;
            5: res = oldf - d;
            default: res = d;
        endcase
        res = res & mask;
        if (wr) begin
            for (int k = 0; k < width; k++) begin
                logic [19:0] ba;
                ba = a + 20'(k);
                ref_mem[ba[13:4]][ba[3:0]] = res[k];
            end
            exp = res;
        end else begin
            exp = oldf | ((sx && oldf[width-1]) ? ~mask : 32'h0);
        end
        rd_exp = 0;
        for (int i = 0; i < 3; i++) begin
            skip[i] = wr && (nop == 0) && (i < n) && (i*16 >= off) &&
                      (i*16 + 15 <= off + width - 1);
            if (i < n && !skip[i]) rd_exp++;
        end
        // Present the request for one accepting edge.
        req_addr = a; req_wlen = wm1; req_write = wr; req_op = op;
        req_sext = sx; req_wdata = d; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 32'h0);
        rd_cnt = 0; wr_cnt = 0; cyc = 0;
        while (!rsp_done && cyc < 100) begin
            // Per-clock strobe checks against the predicted word sets.
            if (mem_re && mem_we)
                chk(1'b0, "R10", "re and we together", 32'h1, 32'h0);
            if (mem_re) begin
                int i;
                i = int'(16'(mem_addr - base));
                chk(i < n, "R2", "read outside span", 32'(mem_addr), 32'(base));
                if (i < n)
                    chk(!skip[i], "R7", "read of fully covered word",
                        32'(mem_addr), 32'(base));
                rd_cnt++;
            end
            if (mem_we) begin
                chk(mem_addr == 16'(base + 16'(wr_cnt)), "R2", "write word order",
                    32'(mem_addr), 32'(16'(base + 16'(wr_cnt))));
                wr_cnt++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(rsp_done == 1'b1, "R9", "done pulse seen", 32'(rsp_done), 32'h1);
        chk(rsp_rdata == exp, wr ? "R6" : (sx ? "R4" : "R3"), "response data",
            rsp_rdata, exp);
        chk(rd_cnt == rd_exp, "R7", "memory reads issued", 32'(rd_cnt), 32'(rd_exp));
        chk(wr_cnt == (wr ? n : 0), "R2", "memory writes issued", 32'(wr_cnt),
            32'(wr ? n : 0));
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R9", "done is one cycle",
            32'({rsp_done, req_ready}), 32'h1);
        mem_ok = 1'b1; bad_w = '0;
        for (int j = -1; j <= 3; j++) begin
            logic [15:0] w;
            w = 16'(int'(base) + j);
            if (mem[w[9:0]] !== ref_mem[w[9:0]] && mem_ok) begin
                mem_ok = 1'b0; bad_w = w;
            end
        end
        chk(mem_ok, "R5", "memory around field", 32'(mem[bad_w[9:0]]),
            32'(ref_mem[bad_w[9:0]]));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 16'(i * 40503) ^ 16'h5A5A;
            ref_mem[i] = 16'(i * 40503) ^ 16'h5A5A;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !mem_re && !mem_we && !rsp_done, "R1", "reset outputs",
            32'({req_ready, mem_re, mem_we, rsp_done}), 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_re && !mem_we && !rsp_done, "R1", "after reset",
            32'({req_ready, mem_re, mem_we, rsp_done}), 32'h8);
        // R3 aligned word, single bit, R8 full width
        do_req(20'h00100, 5'd15, 1'b0, 3'd0, 1'b0, 32'h0);
        do_req(20'h00107, 5'd0,  1'b0, 3'd0, 1'b0, 32'h0);
        do_req(20'h0020F, 5'd31, 1'b0, 3'd0, 1'b0, 32'h0);
        // R4 sign extension on a three-word field
        do_req(20'h0030F, 5'd31, 1'b0, 3'd0, 1'b1, 32'h0);
        do_req(20'h00305, 5'd6,  1'b0, 3'd0, 1'b1, 32'h0);
        do_req(20'h00305, 5'd6,  1'b0, 3'd5, 1'b0, 32'h0);
        // R7 plain stores with fully covered words
        do_req(20'h00400, 5'd15, 1'b1, 3'd0, 1'b0, 32'hBEEF);
        do_req(20'h00500, 5'd31, 1'b1, 3'd0, 1'b0, 32'hCAFE_F00D);
        do_req(20'h00608, 5'd31, 1'b1, 3'd0, 1'b0, 32'h1234_5678);
        do_req(20'h00608, 5'd31, 1'b0, 3'd0, 1'b0, 32'h0);
        // R6 every operation at odd offsets, codes 6 and 7
        for (int c = 0; c < 8; c++) begin
            do_req(20'h00703 + 20'(c * 37), 5'd12, 1'b1, 3'(c), 1'b0, 32'h0000_1A5C);
            do_req(20'h00703 + 20'(c * 37), 5'd12, 1'b0, 3'd0, 1'b0, 32'h0);
        end
        // R2 wrap of the word address
        do_req(20'hFFFF8, 5'd19, 1'b1, 3'd4, 1'b0, 32'h000F_0F0F);
        do_req(20'hFFFF8, 5'd19, 1'b0, 3'd0, 1'b1, 32'h0);
        // Randomized mix
        for (int t = 0; t < 400; t++) begin
            logic [19:0] ra;
            ra = 20'($urandom_range(0, 16'h3FF0));
            do_req(ra, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                   3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule